// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block lets a synchronous on-chip bus fetch data from an external, unclocked mask ROM. The ROM can serve 16-bit words or 8-bit bytes. A requester raises a request strobe with a byte address and a width select. The controller accepts the request when it is idle and drives the ROM address, a combined chip-enable/output-enable pair and the word/byte select. It then waits a fixed number of clock cycles for the data to settle and registers the data. It returns the value with a one-cycle response pulse and waits out the time the ROM needs to float its outputs before it takes the next request.

The ROM's most significant data pin changes role with the width. In word mode the ROM drives it as data bit 15. In byte mode it is an input that carries the least significant byte-address bit. The controller presents that pin as a pad triple: an input value, an output value and an output enable. It turns the pin around with the width select. In byte mode the byte is zero-extended onto the response bus.

All wait counts come from a speed-grade parameter and the clock period. Each count is the ceiling of the grade's nanosecond figure divided by the clock period, so one netlist serves the 80 ns, 100 ns and 120 ns parts.

Top module: `rom_fetch_ctrl`

## Requirements
- R1: During and directly after reset, req_ready is 1, rom_ce_n and rom_oe_n are 1, rsp_valid is 0 and rom_top_oe is 0.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both 1. From the next cycle req_ready is 0 until the transaction ends. A request held with req_valid=1 while busy is accepted once req_ready returns, and is never lost, so every request yields exactly one response.
- R3: At the accepting edge rom_addr takes req_addr[18:1], and rom_ce_n and rom_oe_n both go to 0. In word mode req_addr[0] has no effect on the returned data.
- R4: rom_ce_n and rom_oe_n stay 0 for exactly ACC+2 cycles. ACC is the ceiling of max(access time, output-enable time) divided by CLK_PERIOD_NS. The speed grade sets the access and output-enable times: grade 0 gives 80/40 ns, grade 1 gives 100/50 ns and grade 2 gives 120/60 ns.
- R5: rsp_valid is 1 for exactly one cycle, the first cycle in which rom_ce_n is back at 1. In word mode (req_byte=0) rsp_data equals {rom_top_in, rom_dq[14:0]} as sampled at the edge that raised rom_ce_n.
- R6: In byte mode (req_byte=1) rsp_data equals {8'h00, rom_dq[7:0]}. The values on rom_dq[14:8] have no effect.
- R7: In byte mode rom_top_oe is 1 and rom_top_out equals req_addr[0] from the accepting edge until req_ready returns to 1. In word mode, and whenever idle, rom_top_oe is 0.
- R8: After rom_ce_n returns to 1, req_ready stays 0 for DF more cycles, where DF is the ceiling of 20 ns divided by CLK_PERIOD_NS. The whole transaction therefore keeps req_ready at 0 for ACC+2+DF cycles.
- R9: rom_addr, rom_wide (1 = word mode, 0 = byte mode) and rom_top_out do not change from the accepting edge until req_ready returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, held until accepted |
| req_addr | input | 19 | Byte address; bit 0 selects the byte in byte mode |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Read data, zero-extended in byte mode |
| rom_addr | output | 18 | ROM word-address lines |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_wide | output | 1 | ROM width select: 1 word, 0 byte |
| rom_dq | input | 15 | ROM data lines 0 to 14 |
| rom_top_in | input | 1 | Shared top pin, input side |
| rom_top_out | output | 1 | Shared top pin, value driven in byte mode |
| rom_top_oe | output | 1 | Shared top pin, output enable |

## Verification
A sequencer that leaves its wait state early or late changes how long rom_ce_n stays low. The compare made each cycle shows this on the very cycle the enable rises or fails to rise. An early capture is also caught through the ROM model, which presents inverted data until every access time has elapsed, so the response word is wrong on its one valid cycle. A datapath that loses the mode or the address shows as a wrong rom_addr, rom_wide or top-pin enable during the busy cycles, or as contention that the ROM model records on the shared pin. A wrong recovery count shows as req_ready returning one or more cycles off.

// File: rtl/rom_fetch_pkg.sv
package rom_fetch_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WAIT,
      ST_CAPTURE,
      ST_RECOVER
   } fetch_state_e;

   localparam int FLOAT_NS   = 20;
   localparam int SLOWEST_NS = 120;

   function automatic int cycles_for(input int ns, input int period);
      return (ns + period - 1) / period;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int access_ns(input int grade);
      case (grade)
         0:       return 80;
         1:       return 100;
         default: return 120;
      endcase
   endfunction

   function automatic int enable_ns(input int grade);
      case (grade)
         0:       return 40;
         1:       return 50;
         default: return 60;
      endcase
   endfunction

endpackage

// File: rtl/rom_fetch_timing.sv
module rom_fetch_timing
   import rom_fetch_pkg::*;
#(
   parameter int SPEED_GRADE   = 2,
   parameter int CLK_PERIOD_NS = 10,
   parameter int CNT_W         = 5
) (
   output logic [CNT_W-1:0] acc_cycles,
   output logic [CNT_W-1:0] float_cycles
);

   localparam int FLT = cycles_for(FLOAT_NS, CLK_PERIOD_NS);

   generate
      case (SPEED_GRADE)
         0: begin : g_grade_fast
            localparam int ACC = imax(cycles_for(80, CLK_PERIOD_NS),
                                      cycles_for(40, CLK_PERIOD_NS));
            assign acc_cycles = CNT_W'(ACC);
         end
         1: begin : g_grade_mid
            localparam int ACC = imax(cycles_for(100, CLK_PERIOD_NS),
                                      cycles_for(50, CLK_PERIOD_NS));
            assign acc_cycles = CNT_W'(ACC);
         end
         default: begin : g_grade_slow
            localparam int ACC = imax(cycles_for(120, CLK_PERIOD_NS),
                                      cycles_for(60, CLK_PERIOD_NS));
            assign acc_cycles = CNT_W'(ACC);
         end
      endcase
   endgenerate

   assign float_cycles = CNT_W'(FLT);

endmodule

// File: rtl/rom_fetch_seq.sv
module rom_fetch_seq
   import rom_fetch_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] acc_cycles,
   input  logic [CNT_W-1:0] float_cycles,
   output logic             ready,
   output logic             ctl_n,
   output logic             capture,
   output logic             finish
);

   fetch_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ctl_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ctl_n_q <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SETUP;
                  ctl_n_q <= 1'b0;
               end
            end
            ST_SETUP: begin
               state_q <= ST_WAIT;
               cnt_q   <= acc_cycles - 1'b1;
            end
            ST_WAIT: begin
               if (cnt_q == '0) begin
                  state_q <= ST_CAPTURE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_CAPTURE: begin
               state_q <= ST_RECOVER;
               ctl_n_q <= 1'b1;
               cnt_q   <= float_cycles - 1'b1;
            end
            ST_RECOVER: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               ctl_n_q <= 1'b1;
            end
         endcase
      end
   end

   assign ready   = (state_q == ST_IDLE);
   assign ctl_n   = ctl_n_q;
   assign capture = (state_q == ST_CAPTURE);
   assign finish  = (state_q == ST_RECOVER) && (cnt_q == '0);

endmodule

// File: rtl/rom_fetch_path.sv
module rom_fetch_path #(
   parameter int WORD_AW = 18,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               capture,
   input  logic               finish,
   input  logic [WORD_AW:0]   req_addr,
   input  logic               req_byte,
   input  logic [DATA_W-2:0]  rom_dq,
   input  logic               rom_top_in,
   output logic [WORD_AW-1:0] rom_addr,
   output logic               rom_wide,
   output logic               rom_top_out,
   output logic               rom_top_oe,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data
);

   localparam int LANE_W = 8;
   localparam int LANES  = DATA_W / LANE_W;

   logic [WORD_AW-1:0]            addr_q;
   logic                          wide_q;
   logic                          top_out_q;
   logic                          top_oe_q;
   logic                          rsp_valid_q;
   logic [DATA_W-1:0]             rsp_q;
   logic [DATA_W-1:0]             pins;
   logic [LANES-1:0][LANE_W-1:0]  lane_d;

   assign pins = {rom_top_in, rom_dq};

   // Lane 0 always carries the fetched byte; the upper lanes are zeroed in byte mode.
   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (l == 0) begin : g_low
            assign lane_d[l] = pins[LANE_W-1:0];
         end else begin : g_high
            assign lane_d[l] = wide_q ? pins[l*LANE_W +: LANE_W] : '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wide_q    <= 1'b1;
         top_out_q <= 1'b0;
         top_oe_q  <= 1'b0;
      end else if (start) begin
         addr_q    <= req_addr[WORD_AW:1];
         wide_q    <= ~req_byte;
         top_out_q <= req_addr[0];
         top_oe_q  <= req_byte;
      end else if (finish) begin
         top_oe_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_q       <= '0;
      end else begin
         rsp_valid_q <= capture;
         if (capture) begin
            rsp_q <= lane_d;
         end
      end
   end

   assign rom_addr    = addr_q;
   assign rom_wide    = wide_q;
   assign rom_top_out = top_out_q;
   assign rom_top_oe  = top_oe_q;
   assign rsp_valid   = rsp_valid_q;
   assign rsp_data    = rsp_q;

endmodule

// File: rtl/rom_fetch_ctrl.sv
module rom_fetch_ctrl
   import rom_fetch_pkg::*;
#(
   parameter int SPEED_GRADE   = 2,
   parameter int CLK_PERIOD_NS = 10,
   parameter int WORD_AW       = 18,
   parameter int DATA_W        = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [WORD_AW:0]   req_addr,
   input  logic               req_byte,
   output logic               req_ready,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic [WORD_AW-1:0] rom_addr,
   output logic               rom_ce_n,
   output logic               rom_oe_n,
   output logic               rom_wide,
   input  logic [DATA_W-2:0]  rom_dq,
   input  logic               rom_top_in,
   output logic               rom_top_out,
   output logic               rom_top_oe
);

   localparam int SLOW_CYC = cycles_for(SLOWEST_NS, CLK_PERIOD_NS);
   localparam int CNT_W    = $clog2(SLOW_CYC + 1) + 1;

   generate
      if (SPEED_GRADE < 0 || SPEED_GRADE > 2) begin : g_bad_grade
         $error("SPEED_GRADE must be 0, 1 or 2");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be at least 1");
      end
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (WORD_AW < 1) begin : g_bad_aw
         $error("WORD_AW must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] acc_cycles;
   logic [CNT_W-1:0] float_cycles;
   logic             start;
   logic             ctl_n;
   logic             capture;
   logic             finish;

   rom_fetch_timing #(
      .SPEED_GRADE  (SPEED_GRADE),
      .CLK_PERIOD_NS(CLK_PERIOD_NS),
      .CNT_W        (CNT_W)
   ) u_timing (
      .acc_cycles  (acc_cycles),
      .float_cycles(float_cycles)
   );

   assign start = req_valid & req_ready;

   rom_fetch_seq #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .acc_cycles  (acc_cycles),
      .float_cycles(float_cycles),
      .ready       (req_ready),
      .ctl_n       (ctl_n),
      .capture     (capture),
      .finish      (finish)
   );

   rom_fetch_path #(
      .WORD_AW(WORD_AW),
      .DATA_W (DATA_W)
   ) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .capture    (capture),
      .finish     (finish),
      .req_addr   (req_addr),
      .req_byte   (req_byte),
      .rom_dq     (rom_dq),
      .rom_top_in (rom_top_in),
      .rom_addr   (rom_addr),
      .rom_wide   (rom_wide),
      .rom_top_out(rom_top_out),
      .rom_top_oe (rom_top_oe),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   assign rom_ce_n = ctl_n;
   assign rom_oe_n = ctl_n;

endmodule

// File: rtl/rom_fetch_chk.sv
module rom_fetch_chk
   import rom_fetch_pkg::*;
#(
   parameter int SPEED_GRADE   = 2,
   parameter int CLK_PERIOD_NS = 10,
   parameter int WORD_AW       = 18,
   parameter int DATA_W        = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic [DATA_W-9:0]  rsp_upper,
   input logic [WORD_AW-1:0] rom_addr,
   input logic               rom_ce_n,
   input logic               rom_oe_n,
   input logic               rom_wide,
   input logic               rom_top_out,
   input logic               rom_top_oe
);

   localparam int LOW_EXP  = imax(cycles_for(access_ns(SPEED_GRADE), CLK_PERIOD_NS),
                                  cycles_for(enable_ns(SPEED_GRADE), CLK_PERIOD_NS)) + 2;
   localparam int BUSY_EXP = LOW_EXP + cycles_for(FLOAT_NS, CLK_PERIOD_NS);

   int low_run;
   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= 0;
         busy_run <= 0;
      end else begin
         low_run  <= rom_ce_n  ? 0 : low_run + 1;
         busy_run <= req_ready ? 0 : busy_run + 1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rom_ce_n && rom_oe_n && !rom_top_oe));

   assert_accept_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> $past(req_valid));

   assert_enable_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_ready) |-> (!rom_ce_n && !rom_oe_n));

   assert_access_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rom_ce_n) |-> (low_run == LOW_EXP));

   assert_rsp_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rom_ce_n && $past(!rom_ce_n)));

   assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_byte_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rom_wide) |-> (rsp_upper == '0));

   assert_top_pin_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (rom_top_oe == !rom_wide));

   assert_recover_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready) |-> (busy_run == BUSY_EXP));

   assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |->
         ($stable(rom_addr) && $stable(rom_wide) && $stable(rom_top_out)));

endmodule

bind rom_fetch_ctrl rom_fetch_chk #(
   .SPEED_GRADE  (SPEED_GRADE),
   .CLK_PERIOD_NS(CLK_PERIOD_NS),
   .WORD_AW      (WORD_AW),
   .DATA_W       (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_upper  (rsp_data[DATA_W-1:8]),
   .rom_addr   (rom_addr),
   .rom_ce_n   (rom_ce_n),
   .rom_oe_n   (rom_oe_n),
   .rom_wide   (rom_wide),
   .rom_top_out(rom_top_out),
   .rom_top_oe (rom_top_oe)
);

// File: tb/rom_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module rom_fetch_ctrl_tb_top;

   localparam int PERIOD = 20;
   localparam int T_AA   = 120;
   localparam int T_OE   = 60;
   localparam int T_DF   = 20;
   localparam int ACC    = (T_AA + PERIOD - 1) / PERIOD;
   localparam int DF     = (T_DF + PERIOD - 1) / PERIOD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [18:0] req_addr = '0;
   logic        req_byte = 1'b0;
   logic        req_ready;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic [17:0] rom_addr;
   logic        rom_ce_n;
   logic        rom_oe_n;
   logic        rom_wide;
   logic [14:0] rom_dq = '0;
   logic        rom_top_in = 1'b0;
   logic        rom_top_out;
   logic        rom_top_oe;

   int n_chk = 0;
   int n_fail = 0;
   int n_sent = 0;
   int n_rsp = 0;
   int contention = 0;
   bit done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   rom_fetch_ctrl #(
      .SPEED_GRADE  (2),
      .CLK_PERIOD_NS(PERIOD),
      .WORD_AW      (18),
      .DATA_W       (16)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_byte   (req_byte),
      .req_ready  (req_ready),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .rom_addr   (rom_addr),
      .rom_ce_n   (rom_ce_n),
      .rom_oe_n   (rom_oe_n),
      .rom_wide   (rom_wide),
      .rom_dq     (rom_dq),
      .rom_top_in (rom_top_in),
      .rom_top_out(rom_top_out),
      .rom_top_oe (rom_top_oe)
   );

   function automatic logic [15:0] pat(input logic [17:0] w);
      logic [31:0] p;
      p = {14'd0, w} * 32'd40503 + 32'd12345;
      return p[15:0] ^ {w[17:16], 14'd0};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   // ROM model: data valid only after all access times since the last change.
   time t_addr = 0, t_ce = 0, t_oe = 0, t_off = 0;
   always @(rom_addr or rom_top_out or rom_top_oe or rom_wide) t_addr = $time;
   always @(negedge rom_ce_n) t_ce = $time;
   always @(negedge rom_oe_n) t_oe = $time;
   always @(posedge rom_ce_n or posedge rom_oe_n) t_off = $time;

   initial begin
      forever begin
         logic [15:0] w;
         logic [7:0]  sel;
         bit          active, valid, rom_drives;
         #1;
         w      = pat(rom_addr);
         sel    = rom_top_out ? w[15:8] : w[7:0];
         active = !rom_ce_n && !rom_oe_n;
         valid  = active && ($time - t_addr >= T_AA) && ($time - t_ce >= T_AA)
                  && ($time - t_oe >= T_OE);
         rom_drives = rom_wide && (active || ($time - t_off < T_DF));
         if (rom_wide) begin
            if (!valid) w = ~w;
            rom_dq     = w[14:0];
            rom_top_in = rom_drives ? w[15] : 1'b0;
         end else begin
            rom_dq     = {7'h55, valid ? sel : ~sel};
            rom_top_in = rom_top_out;
         end
         if (rom_drives && rom_top_oe) contention++;
      end
   end

   // Cycle reference model of the handshake and pin sequence.
   int          ref_t = -1;
   logic [17:0] e_addr = '0;
   bit          e_byte = 1'b0;
   bit          e_lsb = 1'b0;
   logic [15:0] e_val = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_t = -1;
      end else if (ref_t < 0) begin
         if (req_valid) begin
            logic [15:0] w;
            ref_t  = 0;
            e_addr = req_addr[18:1];
            e_byte = req_byte;
            e_lsb  = req_addr[0];
            w      = pat(req_addr[18:1]);
            e_val  = req_byte ? {8'h00, (req_addr[0] ? w[15:8] : w[7:0])} : w;
         end
      end else if (ref_t == ACC + 1 + DF) begin
         ref_t = -1;
      end else begin
         ref_t++;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
         chk(rom_ce_n && rom_oe_n, "R1 enables", {30'd0, rom_ce_n, rom_oe_n}, 32'd3);
         chk(!rsp_valid && !rom_top_oe, "R1 rsp/top", {30'd0, rsp_valid, rom_top_oe}, 32'd0);
      end else begin
         bit busy;
         busy = (ref_t >= 0);
         chk(req_ready == !busy, (ref_t >= ACC + 2) ? "R8 ready" : "R2 ready",
             32'(req_ready), 32'(!busy));
         chk(rom_ce_n == !(busy && ref_t <= ACC + 1), "R4 ce_n",
             32'(rom_ce_n), 32'(!(busy && ref_t <= ACC + 1)));
         chk(rom_oe_n == !(busy && ref_t <= ACC + 1), "R4 oe_n",
             32'(rom_oe_n), 32'(!(busy && ref_t <= ACC + 1)));
         chk(rsp_valid == (ref_t == ACC + 2), "R5 rsp_valid",
             32'(rsp_valid), 32'(ref_t == ACC + 2));
         if (rsp_valid) n_rsp++;
         if (ref_t == ACC + 2) begin
            chk(rsp_data == e_val, e_byte ? "R6 byte data" : "R5 word data",
                32'(rsp_data), 32'(e_val));
         end
         if (busy) begin
            chk(rom_addr == e_addr, "R3 rom_addr", 32'(rom_addr), 32'(e_addr));
            chk(rom_wide == !e_byte, "R9 rom_wide", 32'(rom_wide), 32'(!e_byte));
            chk(rom_top_oe == e_byte, "R7 top_oe", 32'(rom_top_oe), 32'(e_byte));
            if (e_byte) chk(rom_top_out == e_lsb, "R7 top_out", 32'(rom_top_out), 32'(e_lsb));
         end else begin
            chk(rom_top_oe == 1'b0, "R7 idle top_oe", 32'(rom_top_oe), 32'd0);
         end
      end
   end

   // Called at a falling edge; holds the request until it is taken.
   task automatic send(input logic [18:0] a, input bit b, input int gap);
      req_valid = 1'b1;
      req_addr  = a;
      req_byte  = b;
      n_sent++;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (gap > 0) begin
         req_valid = 1'b0;
         req_addr  = ~a;
         req_byte  = ~b;
         repeat (gap) @(negedge clk);
      end
   endtask

   initial begin
      logic [31:0] s;
      s = 32'h1357_9BDF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Word reads at both address ends, bit 0 set to show it is ignored (R3).
      send(19'h00000, 1'b0, 2);
      send(19'h7FFFF, 1'b0, 1);
      send(19'h12345, 1'b0, 0);
      send(19'h12344, 1'b0, 3);
      // Byte reads of both halves, low and high ends (R6, R7).
      send(19'h00000, 1'b1, 1);
      send(19'h00001, 1'b1, 1);
      send(19'h7FFFE, 1'b1, 0);
      send(19'h7FFFF, 1'b1, 2);
      // Back-to-back mode changes with the strobe held (R2, R7).
      send(19'h2AAAA, 1'b1, 0);
      send(19'h15555, 1'b0, 0);
      send(19'h2AAAB, 1'b1, 0);
      send(19'h0F0F0, 1'b0, 1);
      for (int i = 0; i < 64; i++) begin
         s = s * 32'd1103515245 + 32'd12345;
         send(s[30:12], s[5], int'(s[9:8]));
      end
      req_valid = 1'b0;
      repeat (ACC + DF + 6) @(negedge clk);
      chk(n_rsp == n_sent, "R2 every request answered", 32'(n_rsp), 32'(n_sent));
      chk(contention == 0, "R7 no top-pin contention", 32'(contention), 32'd0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule